// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This controller moves a small microcontroller between normal running and two sleep states. The shallow stop gates the system clock and keeps every register, memory and pin as it is. The deep stop also gates the clock, puts the regulator into standby and freezes the I/O pins. Software asks for a stop with a one-cycle request pulse. A select bit chooses the deep state, and a stop-enable bit must be set or the request is rejected with an illegal-operation pulse.

The deep stop is left like a reset. The controller selects the reset vector, sets a recovery flag and keeps the pins frozen until software writes 1 to an acknowledge bit. The shallow stop is left by the reset pin, by one of five level-sensitive wake lines, or by a debug wake command. Each of these produces a wake-cause code that the CPU uses to pick its vector.

While the debug-enable input is high, a deep-stop request is turned into a shallow stop. In that case the debug clock keeps running and the regulator stays in full regulation. The controller runs on its own free-running low-speed clock, so it can still see a wake while the system clock is gated.

Top module: `lp_stop_ctrl`

## Requirements
- R1: After power-on reset, the outputs are as follows: sys_clk_en=1, reg_standby=0, io_hold=0, recov_flag=0, dbg_clk_en=1, wake_code=0, and no pulse output is high.
- R2: In run, a stop_req with stop_en=1 that does not lead to the deep stop enters the shallow stop. On the next clock, sys_clk_en=0 and io_hold keeps its value.
- R3: In run, a stop_req with stop_en=1, deep_sel=1 and dbg_en=0 enters the deep stop. On the next clock, sys_clk_en=0 and io_hold=1.
- R4: A deep stop request made while dbg_en=1 enters the shallow stop instead. io_hold does not rise.
- R5: A stop_req in run with stop_en=0 raises illegal_op for exactly one cycle, and the clock keeps running.
- R6: A stop_req while stopped is ignored. The controller stays stopped until a wake source appears.
- R7: In the shallow stop, a nonzero wake_irq resumes run on the next clock with wake_code = 2 + the lowest-numbered active line. Line 0 has the highest priority, and the codes are 2 to 6.
- R8: In either stop, reset_pin_n=0 resumes run with wake_code=1 and a one-cycle sys_reset pulse. It has priority over every other wake source.
- R9: In the shallow stop, dbg_wake with dbg_en=1 resumes run with wake_code=7 and a one-cycle dbg_halt pulse. With dbg_en=0, dbg_wake has no effect.
- R10: Any wake from the deep stop gives wake_code=1, a sys_reset pulse and recov_flag=1. io_hold stays at 1.
- R11: In run, ack_wr with ack_wdata=1 clears recov_flag and io_hold on the next clock. ack_wr with ack_wdata=0 changes nothing.
- R12: dbg_clk_en is 1 in run, and during stop it equals dbg_en. reg_standby is 1 only while stopped with dbg_en=0.
- R13: wake_code is cleared to 0 on entry to any stop and keeps its value while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running low-speed controller clock |
| rst_n | input | 1 | Power-on reset, active low |
| stop_req | input | 1 | One-cycle stop request from the CPU |
| stop_en | input | 1 | Stop enable; if low, a request is illegal |
| deep_sel | input | 1 | Selects the deep (pin-freezing) stop |
| dbg_en | input | 1 | Debug session enabled |
| reset_pin_n | input | 1 | External reset pin, active low |
| wake_irq | input | 5 | Level wake lines: timer, low-voltage, ADC, IRQ, keyboard |
| dbg_wake | input | 1 | Debug wake command |
| ack_wr | input | 1 | Write strobe for the acknowledge bit |
| ack_wdata | input | 1 | Value written to the acknowledge bit |
| sys_clk_en | output | 1 | System clock gate enable |
| reg_standby | output | 1 | Regulator standby request |
| io_hold | output | 1 | Freeze the I/O pin latches |
| recov_flag | output | 1 | Deep-stop recovery flag |
| dbg_clk_en | output | 1 | Debug logic clock enable |
| wake_code | output | 3 | Cause of the last wake |
| illegal_op | output | 1 | One-cycle illegal stop request pulse |
| sys_reset | output | 1 | One-cycle full reset request |
| dbg_halt | output | 1 | One-cycle request to enter debug halt |

## Verification
The assertions assume that reset_pin_n is driven low only while the controller is stopped. They also assume that all inputs change only away from the rising clock edge. The bench draws its random inputs with this in mind: it pulls the reset pin low only while its own model says the controller is stopped, and it drives every input on the falling edge. Wake lines are asserted rarely, so that stops last several cycles and the ignored-request case gets exercised.

// File: rtl/lp_stop_ctrl.sv
module lp_stop_ctrl #(
  parameter int NUM_IRQ = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stop_req,
  input  logic               stop_en,
  input  logic               deep_sel,
  input  logic               dbg_en,
  input  logic               reset_pin_n,
  input  logic [NUM_IRQ-1:0] wake_irq,
  input  logic               dbg_wake,
  input  logic               ack_wr,
  input  logic               ack_wdata,
  output logic               sys_clk_en,
  output logic               reg_standby,
  output logic               io_hold,
  output logic               recov_flag,
  output logic               dbg_clk_en,
  output logic [2:0]         wake_code,
  output logic               illegal_op,
  output logic               sys_reset,
  output logic               dbg_halt
);
  typedef enum logic [1:0] {ST_RUN, ST_SHALLOW, ST_DEEP} st_e;

  localparam logic [2:0] CODE_RST = 3'd1;
  localparam logic [2:0] CODE_DBG = 3'd7;

  st_e        st;
  logic [2:0] irq_code;
  logic       any_irq;
  logic       dbg_go;

  assign any_irq     = |wake_irq;
  assign dbg_go      = dbg_wake && dbg_en;
  assign sys_clk_en  = (st == ST_RUN);
  assign reg_standby = (st != ST_RUN) && !dbg_en;
  assign dbg_clk_en  = (st == ST_RUN) || dbg_en;

  always_comb begin
    irq_code = 3'd0;
    for (int i = NUM_IRQ - 1; i >= 0; i--)
      if (wake_irq[i]) irq_code = 3'(i + 2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_RUN;
      io_hold    <= 1'b0;
      recov_flag <= 1'b0;
      wake_code  <= 3'd0;
      illegal_op <= 1'b0;
      sys_reset  <= 1'b0;
      dbg_halt   <= 1'b0;
    end else begin
      illegal_op <= 1'b0;
      sys_reset  <= 1'b0;
      dbg_halt   <= 1'b0;
      case (st)
        ST_RUN: begin
          if (ack_wr && ack_wdata) begin
            io_hold    <= 1'b0;
            recov_flag <= 1'b0;
          end
          if (stop_req) begin
            if (!stop_en) begin
              illegal_op <= 1'b1;
            end else begin
              wake_code <= 3'd0;
              if (deep_sel && !dbg_en) begin
                st      <= ST_DEEP;
                io_hold <= 1'b1;
              end else begin
                st <= ST_SHALLOW;
              end
            end
          end
        end
        ST_SHALLOW: begin
          if (!reset_pin_n) begin
            st        <= ST_RUN;
            wake_code <= CODE_RST;
            sys_reset <= 1'b1;
          end else if (dbg_go) begin
            st        <= ST_RUN;
            wake_code <= CODE_DBG;
            dbg_halt  <= 1'b1;
          end else if (any_irq) begin
            st        <= ST_RUN;
            wake_code <= irq_code;
          end
        end
        ST_DEEP: begin
          if (!reset_pin_n || any_irq || dbg_go) begin
            st         <= ST_RUN;
            wake_code  <= CODE_RST;
            sys_reset  <= 1'b1;
            recov_flag <= 1'b1;
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/lp_stop_ctrl_chk.sv
module lp_stop_ctrl_chk #(
  parameter int NUM_IRQ = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               stop_req,
  input logic               stop_en,
  input logic               deep_sel,
  input logic               dbg_en,
  input logic               reset_pin_n,
  input logic [NUM_IRQ-1:0] wake_irq,
  input logic               dbg_wake,
  input logic               ack_wr,
  input logic               ack_wdata,
  input logic               sys_clk_en,
  input logic               reg_standby,
  input logic               io_hold,
  input logic               recov_flag,
  input logic               dbg_clk_en,
  input logic [2:0]         wake_code,
  input logic               illegal_op,
  input logic               sys_reset,
  input logic               dbg_halt
);
  p_deep_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_clk_en && stop_req && stop_en && deep_sel && !dbg_en) |=> (!sys_clk_en && io_hold));

  p_dbg_no_deep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_clk_en && stop_req && stop_en && dbg_en && !io_hold) |=> (!sys_clk_en && !io_hold));

  p_illegal_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_clk_en && stop_req && !stop_en) |=> (sys_clk_en && illegal_op));

  p_stay_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_clk_en && reset_pin_n && !(|wake_irq) && !(dbg_wake && dbg_en)) |=> !sys_clk_en);

  p_reset_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_clk_en && !reset_pin_n) |=> (sys_clk_en && sys_reset && wake_code == 3'd1));

  p_halt_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_halt |-> (wake_code == 3'd7 && sys_clk_en));

  p_recov_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    recov_flag |-> io_hold);

  p_ack_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_clk_en && ack_wr && ack_wdata && !stop_req) |=> (!recov_flag && !io_hold));

  p_ack_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_clk_en && !(ack_wr && ack_wdata) && !stop_req) |=> ($stable(recov_flag) && $stable(io_hold)));

  p_dbg_clock_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_en |-> (dbg_clk_en && !reg_standby));

  p_code_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_clk_en && stop_req && stop_en) |=> (wake_code == 3'd0));
endmodule

bind lp_stop_ctrl lp_stop_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .stop_en(stop_en),
  .deep_sel(deep_sel), .dbg_en(dbg_en), .reset_pin_n(reset_pin_n),
  .wake_irq(wake_irq), .dbg_wake(dbg_wake), .ack_wr(ack_wr),
  .ack_wdata(ack_wdata), .sys_clk_en(sys_clk_en), .reg_standby(reg_standby),
  .io_hold(io_hold), .recov_flag(recov_flag), .dbg_clk_en(dbg_clk_en),
  .wake_code(wake_code), .illegal_op(illegal_op), .sys_reset(sys_reset),
  .dbg_halt(dbg_halt)
);

// File: tb/lp_stop_ctrl_tb.sv
`timescale 1ns/1ps
module lp_stop_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_req = 0, stop_en = 0, deep_sel = 0, dbg_en = 0;
  logic       reset_pin_n = 1, dbg_wake = 0, ack_wr = 0, ack_wdata = 0;
  logic [4:0] wake_irq = '0;
  logic       sys_clk_en, reg_standby, io_hold, recov_flag, dbg_clk_en;
  logic [2:0] wake_code;
  logic       illegal_op, sys_reset, dbg_halt;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int       m_st = 0;
  bit       m_hold = 0, m_recov = 0;
  bit [2:0] m_code = 0;
  bit       e_ill = 0, e_rst = 0, e_halt = 0;

  always #2.5 clk = ~clk;

  lp_stop_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .stop_en(stop_en),
    .deep_sel(deep_sel), .dbg_en(dbg_en), .reset_pin_n(reset_pin_n),
    .wake_irq(wake_irq), .dbg_wake(dbg_wake), .ack_wr(ack_wr),
    .ack_wdata(ack_wdata), .sys_clk_en(sys_clk_en), .reg_standby(reg_standby),
    .io_hold(io_hold), .recov_flag(recov_flag), .dbg_clk_en(dbg_clk_en),
    .wake_code(wake_code), .illegal_op(illegal_op), .sys_reset(sys_reset),
    .dbg_halt(dbg_halt)
  );

  function automatic bit [2:0] prio(bit [4:0] v);
    for (int i = 0; i < 5; i++) if (v[i]) return 3'(i + 2);
    return 3'd0;
  endfunction

  task automatic chk(string ctx, string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", ctx, tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string ctx);
    chk(ctx, "R2 sys_clk_en", sys_clk_en, m_st == 0);
    chk(ctx, "R12 reg_standby", reg_standby, (m_st != 0) && !dbg_en);
    chk(ctx, "R12 dbg_clk_en", dbg_clk_en, (m_st == 0) || dbg_en);
    chk(ctx, "R3 io_hold", io_hold, m_hold);
    chk(ctx, "R10 recov_flag", recov_flag, m_recov);
    chk(ctx, "R7 wake_code", wake_code, m_code);
    chk(ctx, "R5 illegal_op", illegal_op, e_ill);
    chk(ctx, "R8 sys_reset", sys_reset, e_rst);
    chk(ctx, "R9 dbg_halt", dbg_halt, e_halt);
  endtask

  task automatic cyc(string ctx, bit sr, bit se, bit ds, bit de, bit rp,
                     bit [4:0] irq, bit dw, bit aw, bit ad);
    @(negedge clk);
    stop_req = sr; stop_en = se; deep_sel = ds; dbg_en = de; reset_pin_n = rp;
    wake_irq = irq; dbg_wake = dw; ack_wr = aw; ack_wdata = ad;
    e_ill = 0; e_rst = 0; e_halt = 0;
    case (m_st)
      0: begin
        if (aw && ad) begin m_hold = 0; m_recov = 0; end
        if (sr) begin
          if (!se) e_ill = 1;
          else begin
            m_code = 0;
            if (ds && !de) begin m_st = 2; m_hold = 1; end
            else m_st = 1;
          end
        end
      end
      1: begin
        if (!rp) begin m_st = 0; m_code = 1; e_rst = 1; end
        else if (dw && de) begin m_st = 0; m_code = 7; e_halt = 1; end
        else if (irq != 0) begin m_st = 0; m_code = prio(irq); end
      end
      default: begin
        if (!rp || irq != 0 || (dw && de)) begin
          m_st = 0; m_code = 1; e_rst = 1; m_recov = 1;
        end
      end
    endcase
    @(posedge clk);
    #1;
    check_all(ctx);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 reset");
    @(negedge clk) rst_n = 1'b1;

    // R5: illegal request, then R13 code stays
    cyc("R5 illegal", 1, 0, 0, 0, 1, 0, 0, 0, 0);
    cyc("R5 after", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    // R3 deep entry, R6 ignored request, R10 deep wake
    cyc("R3 deep", 1, 1, 1, 0, 1, 0, 0, 0, 0);
    cyc("R6 ignore", 1, 1, 0, 0, 1, 0, 0, 0, 0);
    cyc("R6 idle", 0, 0, 0, 0, 1, 0, 0, 1, 1);
    cyc("R10 wake", 0, 0, 0, 0, 1, 5'b01000, 0, 0, 0);
    cyc("R10 hold", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    // R11 ack 0 then ack 1
    cyc("R11 ack0", 0, 0, 0, 0, 1, 0, 0, 1, 0);
    cyc("R11 ack1", 0, 0, 0, 0, 1, 0, 0, 1, 1);
    // R4 deep request with debug enabled
    cyc("R4 dbg deep", 1, 1, 1, 1, 1, 0, 0, 0, 0);
    cyc("R12 dbg stop", 0, 0, 0, 1, 1, 0, 0, 0, 0);
    cyc("R12 nodbg stop", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    // R9 debug wake ignored without enable, then taken
    cyc("R9 ignored", 0, 0, 0, 0, 1, 0, 1, 0, 0);
    cyc("R9 taken", 0, 0, 0, 1, 1, 0, 1, 0, 0);
    // R7 priority
    cyc("R2 shallow", 1, 1, 0, 0, 1, 0, 0, 0, 0);
    cyc("R7 prio", 0, 0, 0, 0, 1, 5'b10100, 0, 0, 0);
    cyc("R13 hold", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    // R8 reset pin beats everything
    cyc("R2 shallow2", 1, 1, 0, 1, 1, 0, 0, 0, 0);
    cyc("R8 reset", 0, 0, 0, 1, 0, 5'b11111, 1, 0, 0);

    for (int n = 0; n < 4000; n++) begin
      bit sr, se, ds, de, rp, dw, aw, ad;
      bit [4:0] irq;
      sr  = ($urandom % 4) == 0;
      se  = ($urandom % 5) != 0;
      ds  = $urandom % 2;
      de  = ($urandom % 4) == 0;
      rp  = !((m_st != 0) && (($urandom % 20) == 0));
      irq = (($urandom % 6) == 0) ? 5'($urandom % 32) : 5'd0;
      dw  = ($urandom % 10) == 0;
      aw  = ($urandom % 6) == 0;
      ad  = $urandom % 2;
      cyc("RND", sr, se, ds, de, rp, irq, dw, aw, ad);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule